// File: doc/BRIEF.md
# Fixed-Order Interrupt Request Resolver

This block watches the eleven interrupt request lines of an expansion bus and reports, one at a time, the pending request with the highest priority. Priority does not follow the line number. Lines 9 to 12, 14 and 15 rank above lines 3 to 7, and lines 0, 1, 2, 8 and 13 do not exist on the bus. Each line is set separately to one of two modes. In edge mode, a rising edge is latched. In level mode, a line that is never shared simply stays high until its cause is removed.

The resolved request leaves the block on a valid/ready stream that carries a 4-bit line number. A transfer happens on a clock edge where both `req_valid` and `req_ready` are high, and that transfer is the acknowledge. While `req_ready` is held low, the reported number stays frozen, even if a request of higher priority arrives. After a transfer, `req_valid` is low for one cycle. The next winner is then chosen from the requests still pending.

For the slave side, the block also contains a request pulse generator. A start command produces one high pulse whose length is clamped to the legal window of 125 ns to 1 ms. At the 100 MHz design clock this is 13 to 100000 cycles.

Top module: `irq_resolver`

## Requirements
- R1: While `rst_n` is low and just after it is released, `req_valid` and `gen_pulse` are low.
- R2: Requests on lines 0, 1, 2, 8 and 13 are ignored in either mode, and `req_valid` stays low. A reported number is always one of 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 or 15.
- R3: When an idle edge-mode line is raised just after a clock edge, `req_valid` is still low three edges later. It rises with `req_num` equal to the line number on the fourth edge.
- R4: When several requests are pending, they are reported in the order 9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_num` does not change, even if a higher-priority request arrives.
- R6: A transfer clears only the reported line. `req_valid` is low in the cycle after the transfer and high again one cycle later if any request remains. An edge-mode line that stays high is not reported again.
- R7: An edge-mode request is latched even if the line goes low again after a single cycle.
- R8: A rising edge detected on the same clock edge as the transfer of that line, or at any later edge, is latched again and reported again.
- R9: A level-mode line is reported again after each transfer for as long as it stays high. Once it has been low for four edges, a transfer leaves nothing pending.
- R10: The mode is chosen per line by `level_mode[n]` (1 = level, 0 = edge). A short pulse on a level-mode line is forgotten, while the same pulse on an edge-mode line stays latched.
- R11: `gen_start`, sampled high while the generator is idle, drives `gen_pulse` high on the next edge for exactly `gen_width` cycles. A width below 13 gives 13 cycles.
- R12: A `gen_width` above 100000 gives a pulse of exactly 100000 cycles.
- R13: `gen_start` has no effect while `gen_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock, all logic on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Raw request lines, bit n is line n, asynchronous |
| level_mode | input | 16 | Per-line mode, 1 = level-held, 0 = edge-latched |
| req_valid | output | 1 | A resolved request is on `req_num` |
| req_num | output | 4 | Line number of the resolved request |
| req_ready | input | 1 | Consumer accepts and acknowledges the request |
| gen_start | input | 1 | Start one generated request pulse |
| gen_width | input | 17 | Requested pulse length in cycles, before clamping |
| gen_pulse | output | 1 | Generated request pulse |

## Verification
A line change reaches `req_valid` after four edges: two synchroniser stages, then the pending latch, then the report register. The bench raises a line just after a falling edge and checks the stream at the falling edges that follow the third and fourth rising edges. A transfer drops `req_valid` at the first falling edge after the handshake, and the next winner appears one falling edge later. The bench checks both points in every acknowledge. Generator pulses are measured by counting the falling edges at which `gen_pulse` is high, starting at the falling edge after the start command is sampled.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int NUM_LINES = 16;
  localparam int NUM_W     = $clog2(NUM_LINES);
  localparam int RANKED    = 11;
  localparam int RANK_W    = $clog2(RANKED + 1);

  // bit n set: line n exists on the bus
  localparam logic [NUM_LINES-1:0] LINE_EXISTS = 16'hDEF8;

  // rank 0 is the highest; absent lines get RANKED (never eligible)
  function automatic logic [RANK_W-1:0] line_rank(input int unsigned line);
    case (line)
      9:       return RANK_W'(0);
      10:      return RANK_W'(1);
      11:      return RANK_W'(2);
      12:      return RANK_W'(3);
      14:      return RANK_W'(4);
      15:      return RANK_W'(5);
      3:       return RANK_W'(6);
      4:       return RANK_W'(7);
      5:       return RANK_W'(8);
      6:       return RANK_W'(9);
      7:       return RANK_W'(10);
      default: return RANK_W'(RANKED);
    endcase
  endfunction

  typedef struct packed {
    logic             hit;
    logic [NUM_W-1:0] num;
  } pick_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_res_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_sync,
  input  logic [NUM_LINES-1:0] level_sel,
  input  logic                 clr_en,
  input  logic [NUM_W-1:0]     clr_num,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] pend_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise;
    logic clr_this;
    assign rise     = line_sync[i] & ~prev_q[i];
    assign clr_this = clr_en && (clr_num == NUM_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= line_sync[i];
        if (level_sel[i])
          pend_q[i] <= line_sync[i];
        else
          pend_q[i] <= rise | (pend_q[i] & ~clr_this);
      end
    end
  end

  assign pend = pend_q & LINE_EXISTS;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_res_pkg::*;
(
  input  logic [NUM_LINES-1:0] pend,
  output pick_t                pick
);
  always_comb begin
    logic [RANK_W-1:0] best;
    best     = RANK_W'(RANKED);
    pick.hit = 1'b0;
    pick.num = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i] && (line_rank(i) < best)) begin
        best     = line_rank(i);
        pick.hit = 1'b1;
        pick.num = NUM_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int MIN_CYC = 13,
  parameter int MAX_CYC = 100000,
  localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;

  always_comb begin
    if (width < CNT_W'(MIN_CYC))      len = CNT_W'(MIN_CYC);
    else if (width > CNT_W'(MAX_CYC)) len = CNT_W'(MAX_CYC);
    else                              len = width;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    else if (start)         cnt_q <= len;
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 13,
  parameter int MAX_PULSE   = 100000,
  localparam int GW         = $clog2(MAX_PULSE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_LINES-1:0] level_mode,
  output logic                 req_valid,
  output logic [NUM_W-1:0]     req_num,
  input  logic                 req_ready,
  input  logic                 gen_start,
  input  logic [GW-1:0]        gen_width,
  output logic                 gen_pulse
);
  logic [NUM_LINES-1:0] lines_m;
  logic [NUM_LINES-1:0] lines_s;
  logic [NUM_LINES-1:0] pend;
  pick_t                pick;
  logic                 take;
  logic                 gnt_v_q;
  logic [NUM_W-1:0]     gnt_n_q;

  assign lines_m = irq_lines & LINE_EXISTS;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lines_m), .q(lines_s)
  );

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .line_sync(lines_s), .level_sel(level_mode),
    .clr_en(take), .clr_num(gnt_n_q), .pend(pend)
  );

  irq_prio_pick u_pick (.pend(pend), .pick(pick));

  assign take = gnt_v_q & req_ready;

  // report register: frozen until accepted, one idle cycle after a transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_v_q <= 1'b0;
      gnt_n_q <= '0;
    end else if (take) begin
      gnt_v_q <= 1'b0;
    end else if (!gnt_v_q && pick.hit) begin
      gnt_v_q <= 1'b1;
      gnt_n_q <= pick.num;
    end
  end

  assign req_valid = gnt_v_q;
  assign req_num   = gnt_n_q;

  irq_pulse_gen #(.MIN_CYC(MIN_PULSE), .MAX_CYC(MAX_PULSE)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .width(gen_width),
    .pulse(gen_pulse)
  );
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk
  import irq_res_pkg::*;
#(
  parameter int MIN_PULSE = 13,
  parameter int MAX_PULSE = 100000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [NUM_W-1:0] req_num,
  input logic             req_ready,
  input logic             gen_pulse
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= 0;
    else if (gen_pulse) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  p_absent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> LINE_EXISTS[req_num]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_num)));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_pulse_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_pulse) |-> (hi_cnt >= MIN_PULSE && hi_cnt <= MAX_PULSE));

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!req_valid && !gen_pulse));
endmodule

bind irq_resolver irq_resolver_chk #(.MIN_PULSE(MIN_PULSE), .MAX_PULSE(MAX_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
  .req_ready(req_ready), .gen_pulse(gen_pulse)
);

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic [15:0] level_mode;
  logic        req_valid;
  logic [3:0]  req_num;
  logic        req_ready;
  logic        gen_start;
  logic [16:0] gen_width;
  logic        gen_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .level_mode(level_mode),
    .req_valid(req_valid), .req_num(req_num), .req_ready(req_ready),
    .gen_start(gen_start), .gen_width(gen_width), .gen_pulse(gen_pulse)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // accept the current request; valid must drop at the next falling edge
  task automatic ack(input string req);
    req_ready = 1'b1;
    step(1);
    req_ready = 1'b0;
    check(req, req_valid, 0);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; irq_lines = '0; level_mode = '0; req_ready = 1'b0;
    gen_start = 1'b0; gen_width = '0;
    step(3);
    check("R1 valid in reset", req_valid, 0);
    check("R1 pulse in reset", gen_pulse, 0);
    rst_n = 1'b1;
    step(2);
    check("R1 valid after reset", req_valid, 0);
    check("R1 pulse after reset", gen_pulse, 0);
  endtask

  task automatic t_absent_r2();
    irq_lines = 16'h2107;
    step(8);
    check("R2 absent edge lines", req_valid, 0);
    irq_lines = '0;
    step(4);
    level_mode = 16'h2107;
    irq_lines  = 16'h2107;
    step(8);
    check("R2 absent level lines", req_valid, 0);
    irq_lines = '0; level_mode = '0;
    step(4);
  endtask

  task automatic t_latency_r3();
    irq_lines[12] = 1'b1;
    step(3);
    check("R3 not yet valid", req_valid, 0);
    step(1);
    check("R3 valid on 4th edge", req_valid, 1);
    check("R3 number", req_num, 12);
    irq_lines[12] = 1'b0;
    ack("R3 ack");
    step(4);
    check("R6 no re-report of edge line", req_valid, 0);
  endtask

  task automatic t_order_r4();
    int order [11] = '{9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7};
    irq_lines = 16'hDEF8;
    step(4);
    for (int k = 0; k < 11; k++) begin
      check("R4 valid in order", req_valid, 1);
      check("R4 priority order", req_num, order[k]);
      ack("R6 gap after transfer");
      step(1);
    end
    check("R4 all served", req_valid, 0);
    irq_lines = '0;
    step(4);
  endtask

  task automatic t_hold_r5();
    irq_lines[5] = 1'b1;
    step(4);
    check("R5 first winner", req_num, 5);
    irq_lines[9] = 1'b1;
    step(6);
    check("R5 held valid", req_valid, 1);
    check("R5 held number", req_num, 5);
    ack("R5 ack");
    step(1);
    check("R6 next winner valid", req_valid, 1);
    check("R6 next winner", req_num, 9);
    ack("R6 ack");
    step(1);
    check("R6 only granted line cleared", req_valid, 0);
    irq_lines = '0;
    step(4);
  endtask

  task automatic t_short_r7();
    irq_lines[14] = 1'b1;
    step(1);
    irq_lines[14] = 1'b0;
    step(3);
    check("R7 one-cycle pulse latched", req_valid, 1);
    check("R7 number", req_num, 14);
    ack("R7 ack");
    step(4);
  endtask

  task automatic t_relatch_r8();
    irq_lines[10] = 1'b1;
    step(4);
    check("R8 first report", req_num, 10);
    irq_lines[10] = 1'b0;
    step(4);
    irq_lines[10] = 1'b1;
    step(2);
    ack("R8 ack coincides with new edge");
    step(1);
    check("R8 re-reported", req_valid, 1);
    check("R8 re-reported number", req_num, 10);
    ack("R8 second ack");
    step(3);
    check("R8 nothing more", req_valid, 0);
    irq_lines = '0;
    step(4);
  endtask

  task automatic t_level_r9();
    level_mode[6] = 1'b1;
    irq_lines[6]  = 1'b1;
    step(4);
    check("R9 level valid", req_valid, 1);
    check("R9 level number", req_num, 6);
    ack("R9 ack while high");
    step(1);
    check("R9 re-reported while high", req_valid, 1);
    check("R9 re-reported number", req_num, 6);
    irq_lines[6] = 1'b0;
    step(4);
    ack("R9 ack after release");
    step(3);
    check("R9 released line not reported", req_valid, 0);
    level_mode = '0;
  endtask

  task automatic t_mixed_r10();
    level_mode[4] = 1'b1;
    irq_lines[9]  = 1'b1;
    step(4);
    check("R10 blocker", req_num, 9);
    irq_lines[3] = 1'b1; irq_lines[4] = 1'b1;
    step(1);
    irq_lines[3] = 1'b0; irq_lines[4] = 1'b0;
    step(5);
    irq_lines[9] = 1'b0;
    ack("R10 ack blocker");
    step(1);
    check("R10 edge pulse kept", req_valid, 1);
    check("R10 edge line number", req_num, 3);
    ack("R10 ack edge line");
    step(3);
    check("R10 level pulse forgotten", req_valid, 0);
    level_mode = '0;
    step(2);
  endtask

  task automatic measure(input int w, input int bump_at, output int n);
    gen_start = 1'b1; gen_width = 17'(w);
    step(1);
    gen_start = 1'b0;
    n = 0;
    while (gen_pulse && n < 150000) begin
      n++;
      if (n == bump_at) begin gen_start = 1'b1; gen_width = 17'd50; end
      step(1);
      gen_start = 1'b0;
    end
    step(2);
  endtask

  task automatic t_gen_r11();
    int n;
    measure(20, 0, n);
    check("R11 exact width", n, 20);
    measure(0, 0, n);
    check("R11 minimum clamp", n, 13);
    measure(5, 0, n);
    check("R11 short width clamped", n, 13);
  endtask

  task automatic t_gen_r12();
    int n;
    measure(131071, 0, n);
    check("R12 maximum clamp", n, 100000);
  endtask

  task automatic t_gen_r13();
    int n;
    measure(20, 5, n);
    check("R13 start ignored while busy", n, 20);
    check("R13 idle afterwards", gen_pulse, 0);
  endtask

  initial begin
    t_reset_r1();
    t_absent_r2();
    t_latency_r3();
    t_order_r4();
    t_hold_r5();
    t_short_r7();
    t_relatch_r8();
    t_level_r9();
    t_mixed_r10();
    t_gen_r11();
    t_gen_r12();
    t_gen_r13();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule